// File: doc/BRIEF.md
# Triggered Parallel DAC Waveform Streamer

This block replays one pulse waveform to an 8-bit parallel DAC each time a trigger arrives. A second 8-bit stream of control bytes is replayed alongside it on eight control pins, sample for sample. Both streams reach the block as 32-bit words on two ready/valid inputs. Each word is split into four bytes, and the least significant byte is played first. Memory fetch and waveform computation happen elsewhere. Upstream logic only has to keep the two word streams flowing.

A step divider sets the playback rate. Each sample occupies four steps. The DAC write clock is low for the first two steps and high for the last two, so the converter latches on the rising edge. Software programs a word count per pulse. Once the last sample has played, the block drives every pin to zero and clocks one zero byte into the DAC. It then waits, with the write clock high, for the next trigger. A one-cycle completion strobe marks the end of each pulse.

Top module: `dac_pulse_streamer`

## Requirements
- R1: While reset is held, `dac_data`, `ctl_pins`, `dac_wclk` and `pulse_done` are all zero. After reset the block gives one write-clock rising edge with `dac_data` = 0 and then keeps `dac_wclk` high while it waits.
- R2: One step lasts `step_div` clock cycles, and a `step_div` of 0 or 1 gives one step per clock. For every sample, `dac_wclk` is low for exactly 2 steps before its rising edge.
- R3: Within each 32-bit word, bits 7:0 play first, then 15:8, then 23:16, then 31:24. A pulse has 4 × `word_count` samples, and `dac_data` never changes while `dac_wclk` is high.
- R4: Control byte k appears on `ctl_pins` in the same clock cycle as DAC sample k, taken from `ctl_word` with the same byte order. `ctl_pins` only changes on a falling edge of `dac_wclk`.
- R5: Playback begins only after a trigger. A `trig` high for a single clock cycle while the block waits is held until it is taken, even if that cycle falls between steps or word data is not yet present.
- R6: If a needed word is missing on either stream, the block holds its pins and keeps `dac_wclk` high. It produces no rising edge until both bytes are available, and no byte is repeated or skipped.
- R7: After the last sample, `dac_data`, `ctl_pins` and `dac_wclk` are driven to zero in the same cycle that `pulse_done` is high for one clock. One step later a zero byte is clocked in and the block waits again.
- R8: A trigger that arrives while a pulse plays has no effect. No further pulse starts after the current one ends, even when words are waiting.
- R9: A `word_count` of 0 is treated as 1. The count is sampled when the trigger is taken.
- R10: A word is accepted when its valid and ready signals are both high. Ready is high only while that stream's holding register is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_div | input | DIV_W | Clock cycles per step (0 and 1 both mean every clock) |
| word_count | input | CNT_W | Words per pulse (0 treated as 1) |
| trig | input | 1 | Start request |
| dac_word | input | WORD_W | Packed DAC samples |
| dac_valid | input | 1 | DAC word valid |
| dac_ready | output | 1 | DAC word accepted this cycle when valid |
| ctl_word | input | WORD_W | Packed control bytes |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted this cycle when valid |
| dac_data | output | 8 | DAC data pins |
| dac_wclk | output | 1 | DAC write clock, data latched on rising edge |
| ctl_pins | output | 8 | Control pins |
| pulse_done | output | 1 | One-cycle strobe at the end of a pulse |

## Verification
The table-driven cases vary the step divisor (0, 1, 2, 3, 5) and the pulse length (1 to 4 words). This separates a correct step scale from one off by a step, and a correct byte order from a swapped one. Gaps in the word supply make some cases stall, either mid-pulse or before the first sample. These cases tell a correct hold apart from replaying stale bytes. The directed cases cover three more points: a one-clock trigger that falls between steps, a second trigger during playback that must not start a pulse, and a zero word count that must play exactly one word.

// File: rtl/dstream_pkg.sv
package dstream_pkg;

    localparam int DS_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_ZERO_LO,
        ST_ZERO_HI,
        ST_WAIT,
        ST_PLAY
    } seq_state_t;

    typedef struct packed {
        logic [DS_BYTE_W-1:0] dac;
        logic [DS_BYTE_W-1:0] ctl;
        logic                 wclk;
    } pin_bundle_t;

    function automatic logic [1:0] next_phase(input logic [1:0] ph);
        return ph + 2'd1;
    endfunction

endpackage

// File: rtl/stream_step_div.sv
module stream_step_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div_val <= DIV_W'(1)) ? '0 : div_val - DIV_W'(1);
    end

    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (div_val == $past(div_val)) |-> (cnt_q <= limit));

endmodule

// File: rtl/stream_unpack.sv
module stream_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              consume,
    output logic              avail,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              have_q;

    assign s_ready  = !have_q;
    assign avail    = have_q;
    assign byte_out = word_q[idx_q*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            have_q <= 1'b0;
        end else if (s_valid && !have_q) begin
            word_q <= s_data;
            idx_q  <= '0;
            have_q <= 1'b1;
        end else if (consume && have_q) begin
            if (idx_q == IDX_W'(LANES - 1)) begin
                have_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assert_take_needs_byte_R6: assert property (@(posedge clk) disable iff (rst)
        consume |-> have_q);

    assert_word_held_R3: assert property (@(posedge clk) disable iff (rst)
        (have_q && !consume) |=> ($stable(word_q) && $stable(idx_q) && have_q));

    assert_accept_loads_R10: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> (have_q && idx_q == '0 && word_q == $past(s_data)));

endmodule

// File: rtl/stream_seq.sv
module stream_seq
    import dstream_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 trig,
    input  logic [CNT_W-1:0]     word_count,
    input  logic                 dac_avail,
    input  logic [DS_BYTE_W-1:0] dac_byte,
    input  logic                 ctl_avail,
    input  logic [DS_BYTE_W-1:0] ctl_byte,
    output logic                 take,
    output pin_bundle_t          pins,
    output logic                 done
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SAMP_W = CNT_W + LANE_W;

    seq_state_t        state_q;
    logic [1:0]        phase_q;
    logic [SAMP_W-1:0] samp_q;
    logic [SAMP_W-1:0] last_idx_q;
    logic              pend_q;
    pin_bundle_t       pins_q;
    logic              done_q;

    logic              both_avail;
    logic              at_last;
    logic              start_ok;
    logic              next_ok;
    logic [CNT_W-1:0]  eff_count;

    assign both_avail = dac_avail && ctl_avail;
    assign at_last    = (samp_q == last_idx_q);
    assign eff_count  = (word_count == '0) ? CNT_W'(1) : word_count;
    assign start_ok   = (state_q == ST_WAIT) && (pend_q || trig);
    assign next_ok    = (state_q == ST_PLAY) && (phase_q == 2'd3) && !at_last;
    assign take       = tick && both_avail && (start_ok || next_ok);
    assign pins       = pins_q;
    assign done       = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_ZERO_LO;
            phase_q    <= '0;
            samp_q     <= '0;
            last_idx_q <= '0;
            pend_q     <= 1'b0;
            pins_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;

            if (state_q != ST_WAIT) begin
                pend_q <= 1'b0;
            end else if (take) begin
                pend_q <= 1'b0;
            end else if (trig) begin
                pend_q <= 1'b1;
            end

            if (tick) begin
                unique case (state_q)
                    ST_ZERO_LO: begin
                        pins_q.wclk <= 1'b1;
                        state_q     <= ST_ZERO_HI;
                    end
                    ST_ZERO_HI: begin
                        state_q <= ST_WAIT;
                    end
                    ST_WAIT: begin
                        if (take) begin
                            pins_q     <= '{dac: dac_byte, ctl: ctl_byte, wclk: 1'b0};
                            state_q    <= ST_PLAY;
                            phase_q    <= '0;
                            samp_q     <= '0;
                            last_idx_q <= SAMP_W'(eff_count) * SAMP_W'(LANES) - SAMP_W'(1);
                        end
                    end
                    ST_PLAY: begin
                        if (phase_q != 2'd3) begin
                            phase_q <= next_phase(phase_q);
                            if (phase_q == 2'd1) begin
                                pins_q.wclk <= 1'b1;
                            end
                        end else if (at_last) begin
                            pins_q  <= '0;
                            state_q <= ST_ZERO_LO;
                            done_q  <= 1'b1;
                        end else if (take) begin
                            pins_q  <= '{dac: dac_byte, ctl: ctl_byte, wclk: 1'b0};
                            phase_q <= '0;
                            samp_q  <= samp_q + SAMP_W'(1);
                        end
                    end
                    default: state_q <= ST_ZERO_LO;
                endcase
            end
        end
    end

    assert_wclk_on_step_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pins_q.wclk));

    assert_data_still_high_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(pins_q.dac) |-> !pins_q.wclk);

    assert_ctl_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pins_q.ctl) |-> $fell(pins_q.wclk));

    assert_done_zero_pins_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (pins_q == '0));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_no_pend_in_play_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLAY) |-> !pend_q);

endmodule

// File: rtl/dac_pulse_streamer.sv
module dac_pulse_streamer
    import dstream_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     step_div,
    input  logic [CNT_W-1:0]     word_count,
    input  logic                 trig,
    input  logic [WORD_W-1:0]    dac_word,
    input  logic                 dac_valid,
    output logic                 dac_ready,
    input  logic [WORD_W-1:0]    ctl_word,
    input  logic                 ctl_valid,
    output logic                 ctl_ready,
    output logic [DS_BYTE_W-1:0] dac_data,
    output logic                 dac_wclk,
    output logic [DS_BYTE_W-1:0] ctl_pins,
    output logic                 pulse_done
);
    localparam int LANES   = WORD_W / DS_BYTE_W;
    localparam int STREAMS = 2;

    logic                               tick;
    logic                               take;
    pin_bundle_t                        pins;
    logic [STREAMS-1:0][WORD_W-1:0]     s_data;
    logic [STREAMS-1:0]                 s_valid;
    logic [STREAMS-1:0]                 s_ready;
    logic [STREAMS-1:0]                 s_avail;
    logic [STREAMS-1:0][DS_BYTE_W-1:0]  s_byte;

    assign s_data  = {ctl_word, dac_word};
    assign s_valid = {ctl_valid, dac_valid};
    assign dac_ready = s_ready[0];
    assign ctl_ready = s_ready[1];

    stream_step_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_val (step_div),
        .tick    (tick)
    );

    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        stream_unpack #(.WORD_W(WORD_W), .BYTE_W(DS_BYTE_W)) u_unpack (
            .clk      (clk),
            .rst      (rst),
            .s_data   (s_data[g]),
            .s_valid  (s_valid[g]),
            .s_ready  (s_ready[g]),
            .consume  (take),
            .avail    (s_avail[g]),
            .byte_out (s_byte[g])
        );
    end

    stream_seq #(.CNT_W(CNT_W), .LANES(LANES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .trig       (trig),
        .word_count (word_count),
        .dac_avail  (s_avail[0]),
        .dac_byte   (s_byte[0]),
        .ctl_avail  (s_avail[1]),
        .ctl_byte   (s_byte[1]),
        .take       (take),
        .pins       (pins),
        .done       (pulse_done)
    );

    assign dac_data = pins.dac;
    assign ctl_pins = pins.ctl;
    assign dac_wclk = pins.wclk;

endmodule

// File: tb/dac_pulse_streamer_tb_top.sv
`timescale 1ns/1ps
module dac_pulse_streamer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] step_div = 16'd1;
    logic [15:0] word_count = 16'd1;
    logic        trig = 1'b0;
    logic [31:0] dac_word = '0;
    logic        dac_valid = 1'b0;
    logic        dac_ready;
    logic [31:0] ctl_word = '0;
    logic        ctl_valid = 1'b0;
    logic        ctl_ready;
    logic [7:0]  dac_data;
    logic        dac_wclk;
    logic [7:0]  ctl_pins;
    logic        pulse_done;

    always #4 clk = ~clk;

    dac_pulse_streamer dut_i (
        .clk(clk), .rst(rst), .step_div(step_div), .word_count(word_count), .trig(trig),
        .dac_word(dac_word), .dac_valid(dac_valid), .dac_ready(dac_ready),
        .ctl_word(ctl_word), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .dac_data(dac_data), .dac_wclk(dac_wclk), .ctl_pins(ctl_pins), .pulse_done(pulse_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // capture monitor: one entry per rising edge of the write clock
    logic [7:0] cap_d [0:127];
    logic [7:0] cap_c [0:127];
    int         cap_low [0:127];
    int         cap_n = 0;
    int         low_cnt = 0;
    int         pd_cnt = 0;
    int         pd_bad = 0;
    logic       prev_wclk = 1'b0;
    logic       prev_pd = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_wclk && !prev_wclk && cap_n < 128) begin
                cap_d[cap_n]   = dac_data;
                cap_c[cap_n]   = ctl_pins;
                cap_low[cap_n] = low_cnt;
                cap_n          = cap_n + 1;
            end
            if (!dac_wclk) low_cnt = low_cnt + 1;
            else           low_cnt = 0;
            if (pulse_done) begin
                pd_cnt = pd_cnt + 1;
                if (dac_data != 0 || ctl_pins != 0 || dac_wclk || prev_pd) pd_bad = pd_bad + 1;
            end
        end
        prev_wclk = dac_wclk;
        prev_pd   = pulse_done;
    end

    // expected bytes, LSB-first packing done here
    logic [7:0]  exp_d [0:63];
    logic [7:0]  exp_c [0:63];
    logic [31:0] dw [0:15];
    logic [31:0] cw [0:15];

    task automatic fill(input int seed, input int n);
        for (int k = 0; k < 4 * n; k++) begin
            exp_d[k] = 8'(seed * 29 + k * 13 + 7);
            exp_c[k] = 8'((seed * 5) ^ (k * 3 + 1));
            dw[k / 4][8 * (k % 4) +: 8] = exp_d[k];
            cw[k / 4][8 * (k % 4) +: 8] = exp_c[k];
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic feed(input int lane, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!(lane == 0 ? dac_ready : ctl_ready)) @(negedge clk);
            repeat (gap) @(negedge clk);
            if (lane == 0) begin dac_word = dw[i]; dac_valid = 1'b1; end
            else           begin ctl_word = cw[i]; ctl_valid = 1'b1; end
            @(negedge clk);
            if (lane == 0) dac_valid = 1'b0;
            else           ctl_valid = 1'b0;
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_done(input int p0);
        int t = 0;
        while (pd_cnt == p0 && t < 20000) begin @(negedge clk); t++; end
    endtask

    // compare captures from base b0 against expected bytes from offset e0
    task automatic cmp_samples(input int b0, input int e0, input int ns, input int exp_low, input int div_eff, input string tag);
        int bad_d = 0, bad_c = 0, bad_l = 0;
        for (int i = 0; i < ns; i++) begin
            if (cap_d[b0 + i] != exp_d[e0 + i]) bad_d++;
            if (cap_c[b0 + i] != exp_c[e0 + i]) bad_c++;
            if (exp_low > 0 && cap_low[b0 + i] != exp_low) bad_l++;
        end
        chk(bad_d == 0, "R3", {tag, " dac byte mismatches"}, bad_d, 0);
        chk(bad_c == 0, "R4", {tag, " ctl byte mismatches"}, bad_c, 0);
        if (exp_low > 0) chk(bad_l == 0, "R2", {tag, " low-width mismatches"}, bad_l, 0);
        chk(cap_d[b0 + ns] == 8'd0 && cap_c[b0 + ns] == 8'd0, "R7", {tag, " re-arm zero byte"},
            int'(cap_d[b0 + ns]), 0);
        if (exp_low > 0) chk(cap_low[b0 + ns] == div_eff, "R7", {tag, " re-arm low width"},
            cap_low[b0 + ns], div_eff);
    endtask

    // stimulus/expected table: divider, words, supply gap, expected samples, expected low width
    localparam int NV = 6;
    localparam int V_DIV  [NV] = '{1, 1, 3, 2, 0, 5};
    localparam int V_N    [NV] = '{1, 3, 2, 4, 2, 1};
    localparam int V_GAP  [NV] = '{0, 0, 0, 12, 0, 25};
    localparam int V_SAMP [NV] = '{4, 12, 8, 16, 8, 4};
    localparam int V_LOW  [NV] = '{2, 2, 6, 4, 2, 10};

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        int b0, p0, de;
        // reset state, R1 and R10
        repeat (4) @(negedge clk);
        chk(dac_data == 0 && ctl_pins == 0, "R1", "pins in reset", int'(dac_data), 0);
        chk(dac_wclk == 0 && pulse_done == 0, "R1", "wclk/done in reset", int'(dac_wclk), 0);
        chk(dac_ready && ctl_ready, "R10", "ready when empty", int'(dac_ready), 1);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(cap_n == 1, "R1", "arm edges after reset", cap_n, 1);
        chk(cap_d[0] == 0, "R1", "arm byte", int'(cap_d[0]), 0);
        chk(dac_wclk == 1'b1, "R1", "wclk high while waiting", int'(dac_wclk), 1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            de = (V_DIV[v] < 1) ? 1 : V_DIV[v];
            step_div = 16'(V_DIV[v]);
            word_count = 16'(V_N[v]);
            fill(v + 1, V_N[v]);
            repeat (4) @(negedge clk);
            b0 = cap_n; p0 = pd_cnt;
            fork
                feed(0, V_N[v], V_GAP[v]);
                feed(1, V_N[v], V_GAP[v]);
                begin repeat (2) @(negedge clk); pulse_trig(); end
            join
            wait_done(p0);
            repeat (3 * de + 6) @(negedge clk);
            chk(cap_n - b0 == V_SAMP[v] + 1, "R3", $sformatf("vec%0d edge count", v), cap_n - b0, V_SAMP[v] + 1);
            chk(pd_cnt - p0 == 1, "R7", $sformatf("vec%0d done strobes", v), pd_cnt - p0, 1);
            cmp_samples(b0, 0, V_SAMP[v], V_LOW[v], de, $sformatf("vec%0d", v));
        end
        chk(pd_bad == 0, "R7", "done strobe shape", pd_bad, 0);

        // no start without trigger (R5), ready low while held (R10), retrigger ignored (R8)
        step_div = 16'd2;
        word_count = 16'd2;
        fill(40, 3);
        repeat (6) @(negedge clk);
        b0 = cap_n; p0 = pd_cnt;
        fork
            feed(0, 3, 0);
            feed(1, 3, 0);
        join_none
        repeat (50) @(negedge clk);
        chk(cap_n == b0, "R5", "edges without trigger", cap_n - b0, 0);
        chk(!dac_ready && !ctl_ready, "R10", "ready low while word held", int'(dac_ready), 0);
        pulse_trig();
        repeat (20) @(negedge clk);
        pulse_trig();
        wait_done(p0);
        repeat (200) @(negedge clk);
        chk(cap_n - b0 == 9, "R8", "edges after retrigger", cap_n - b0, 9);
        chk(pd_cnt - p0 == 1, "R8", "pulses after retrigger", pd_cnt - p0, 1);
        cmp_samples(b0, 0, 8, 4, 2, "retrig");

        // zero word count plays one word (R9)
        word_count = 16'd0;
        b0 = cap_n; p0 = pd_cnt;
        pulse_trig();
        wait_done(p0);
        repeat (12) @(negedge clk);
        chk(cap_n - b0 == 5, "R9", "edges for zero count", cap_n - b0, 5);
        cmp_samples(b0, 8, 4, 4, 2, "zero-count");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule